// File: doc/BRIEF.md
# Compare-Match Interval Timer

An 8-bit interval timer for periodic interrupts. A free-running prescaler divides the system clock into four tick rates. A small divider turns an incoming slow-clock pulse into a fifth rate. A selector picks one of these ticks, or a tick from a neighbouring unit, according to a control word, a divider-option bit and a low-power flag. An up-counter advances on the chosen tick. When the tick would bring it to the value in the compare input, the counter returns to zero and the block emits a one-cycle interrupt pulse. Counting then carries on. The interval is therefore the compare value multiplied by the tick period.

The compare input is used directly, with no holding stage, so a new value applies from the next tick. A value of zero gives the longest interval, 256 ticks. A value below the current count is only reached after the counter passes 255 and wraps. Two units can form a 16-bit timer: the lower unit's interrupt drives the chain input of the upper unit, and the upper unit selects that input as its tick.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, `count` is 0 and `irq` is 0.
- R2: The block runs only while `ctrl[3]` (run) is 1 and `ctrl[2:0]` (mode) is 000. In any other case `count` is 0 and `irq` is 0 from the next cycle. When the block is started again, counting begins at 0.
- R3: While the block runs, each selected tick raises `count` by one. Call C the compare value. When a tick would make the count equal to C, `count` becomes 0 instead and `irq` is 1 for exactly that one cycle. The interval is therefore C ticks.
- R4: A compare value of 0 means 256 ticks. The count reaches 255, and the next tick clears it and raises `irq`.
- R5: If the compare value is set below the current count, the counter keeps going up to 255. It then wraps to 0 with no interrupt and matches on the new value later.
- R6: A change on `cmp` takes effect from the next tick, even while the block runs.
- R7: With `div_opt`=0 and `slow_mode`=0, the select field `ctrl[6:4]` picks the tick: 0 gives one tick per 2^11 clock cycles, 1 gives 2^7, 2 gives 2^5 and 3 gives 2^3.
- R8: With `div_opt`=1 and `slow_mode`=0, select 0 gives one tick per 8 `fs_tick` pulses. Selects 1 to 3 keep their R7 rates.
- R9: With `slow_mode`=1, select 0 gives one tick per 8 `fs_tick` pulses whatever the value of `div_opt`. Selects 1 to 3 give no tick.
- R10: Select 4 counts `chain_in` pulses, so two units can be chained. Selects 5 to 7 give no tick.
- R11: If the run bit is cleared in the same cycle as a matching tick, no interrupt is raised and `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle pulse per slow-clock period |
| div_opt | input | 1 | Divider option: moves select 0 onto the slow clock |
| slow_mode | input | 1 | Low-power clock mode flag: the fast ticks are stopped |
| ctrl | input | 8 | Control word: [6:4] select, [3] run, [2:0] mode |
| cmp | input | 8 | Compare value (0 means 256) |
| chain_in | input | 1 | Tick input from a lower unit (select 4) |
| irq | output | 1 | One-cycle interrupt pulse per match |
| count | output | 8 | Current counter value |

## Verification
Two things can fall in the same clock cycle. A tick can complete a match while the run bit drops, and a compare write can arrive on the tick that decides the match. The bench drives the ticks itself through `chain_in`, so both cases can be placed on an exact edge. It clears the run bit together with the matching tick and expects no pulse and a zero count. It lowers the compare value to one above the current count just before a tick and expects that tick to match at once. Interval lengths for the prescaled and slow ticks are judged as the spacing between successive pulses, which does not depend on the prescaler phase.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int CNT_W      = 8;
    localparam int PRE_W      = 11;
    localparam int SLOW_DIV_W = 3;
    localparam int N_FAST     = 4;
    localparam int SEL_W      = 3;
    localparam int MODE_W     = 3;

    localparam logic [MODE_W-1:0] MODE_TIMER = '0;
    localparam logic [SEL_W-1:0]  SEL_CHAIN  = 3'd4;

    typedef struct packed {
        logic              spare;
        logic [SEL_W-1:0]  sel;
        logic              run;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic int fast_shift(input int idx);
        case (idx)
            0:       return 11;
            1:       return 7;
            2:       return 5;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = SLOW_DIV_W,
    parameter int NF = N_FAST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fs_tick,
    output logic [NF-1:0] fast_en,
    output logic          slow_en
);
    logic [PW-1:0] pre_q;
    logic [SW-1:0] fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            fs_q  <= '0;
        end else begin
            pre_q <= pre_q + {{(PW-1){1'b0}}, 1'b1};
            if (fs_tick) fs_q <= fs_q + {{(SW-1){1'b0}}, 1'b1};
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_tap
        localparam int T = fast_shift(i);
        assign fast_en[i] = &pre_q[T-1:0];
    end

    assign slow_en = fs_tick & (&fs_q);

endmodule

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
#(
    parameter int NF = N_FAST
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             div_opt,
    input  logic             slow_mode,
    input  logic [NF-1:0]    fast_en,
    input  logic             slow_en,
    input  logic             chain_in,
    output logic             tick
);
    always_comb begin
        case (sel)
            3'd0:       tick = (div_opt | slow_mode) ? slow_en : fast_en[0];
            3'd1:       tick = ~slow_mode & fast_en[1];
            3'd2:       tick = ~slow_mode & fast_en[2];
            3'd3:       tick = ~slow_mode & fast_en[3];
            SEL_CHAIN:  tick = chain_in;
            default:    tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         irq
);
    logic [W-1:0] count_q;
    logic         irq_q;
    logic [W:0]   limit;
    logic [W:0]   nxt;

    always_comb begin
        limit = (cmp == '0) ? {1'b1, {W{1'b0}}} : {1'b0, cmp};
        nxt   = {1'b0, count_q} + {{W{1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else if (!active) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (tick) begin
                if (nxt == limit) begin
                    count_q <= '0;
                    irq_q   <= 1'b1;
                end else begin
                    count_q <= nxt[W-1:0];
                end
            end
        end
    end

    assign count = count_q;
    assign irq   = irq_q;

endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
    import ivt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NF = N_FAST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fs_tick,
    input  logic         div_opt,
    input  logic         slow_mode,
    input  logic [7:0]   ctrl,
    input  logic [W-1:0] cmp,
    input  logic         chain_in,
    output logic         irq,
    output logic [W-1:0] count
);
    ctrl_t         cw;
    logic [NF-1:0] fast_en;
    logic          slow_en;
    logic          tick;
    logic          active;

    assign cw     = ctrl_t'(ctrl);
    assign active = cw.run && (cw.mode == MODE_TIMER);

    ivt_prescaler #(.PW(PRE_W), .SW(SLOW_DIV_W), .NF(NF)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .fs_tick (fs_tick),
        .fast_en (fast_en),
        .slow_en (slow_en)
    );

    ivt_tick_sel #(.NF(NF)) u_sel (
        .sel       (cw.sel),
        .div_opt   (div_opt),
        .slow_mode (slow_mode),
        .fast_en   (fast_en),
        .slow_en   (slow_en),
        .chain_in  (chain_in),
        .tick      (tick)
    );

    ivt_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tick   (tick),
        .cmp    (cmp),
        .count  (count),
        .irq    (irq)
    );

endmodule

module cmp_interval_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [7:0]   ctrl,
    input logic [W-1:0] count,
    input logic         irq,
    input logic         tick
);
    logic running;
    assign running = ctrl[3] && (ctrl[2:0] == 3'b000);

    // R2, R11
    a_r2_halt_zero: assert property (@(posedge clk) disable iff (rst)
        !ctrl[3] |=> (count == '0 && !irq));

    // R3
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (running && !tick) |=> (count == $past(count) && !irq));

    // R3
    a_r3_step_or_clear: assert property (@(posedge clk) disable iff (rst)
        (running && tick) |=> (count == $past(count) + 1'b1 || (count == '0 && irq)));

    // R3
    a_r3_irq_zero_count: assert property (@(posedge clk) disable iff (rst)
        irq |-> count == '0);

    // R10
    a_r10_idle_select: assert property (@(posedge clk) disable iff (rst)
        (ctrl[6:4] > 3'd4) |-> !tick);

endmodule

bind cmp_interval_timer cmp_interval_timer_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .count (count),
    .irq   (irq),
    .tick  (tick)
);

// File: tb/cmp_interval_timer_tb.sv
module cmp_interval_timer_tb;

    logic       clk = 1'b0;
    logic       rst, fs_tick, div_opt, slow_mode, chain_in;
    logic [7:0] ctrl, cmp, ctrl_hi, cmp_hi;
    logic       irq, irq_hi;
    logic [7:0] count, count_hi;

    int n_chk = 0, n_bad = 0, cyc = 0, irq_cnt = 0, last_irq = 0;
    bit done = 0;

    typedef struct {
        string tag;
        int    gap;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    cmp_interval_timer u_dut (
        .clk(clk), .rst(rst), .fs_tick(fs_tick), .div_opt(div_opt),
        .slow_mode(slow_mode), .ctrl(ctrl), .cmp(cmp), .chain_in(chain_in),
        .irq(irq), .count(count)
    );

    cmp_interval_timer u_hi (
        .clk(clk), .rst(rst), .fs_tick(fs_tick), .div_opt(div_opt),
        .slow_mode(slow_mode), .ctrl(ctrl_hi), .cmp(cmp_hi), .chain_in(irq),
        .irq(irq_hi), .count(count_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic ctick();
        chain_in = 1'b1;
        step();
        chain_in = 1'b0;
    endtask

    task automatic restart(input logic [7:0] run_word);
        ctrl = {run_word[7:4], 1'b0, run_word[2:0]};
        step();
        ctrl = run_word;
        step();
    endtask

    // driver side of the scoreboard: skip one partial interval, then expect one gap
    task automatic expect_gap(input string tag, input int gap);
        int c;
        c = irq_cnt;
        while (irq_cnt == c) step();
        sbq.push_back('{tag, gap});
        while (sbq.size() != 0) step();
    endtask

    // monitor: measures spacing between interrupt pulses
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) begin
            irq_cnt = irq_cnt + 1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, cyc - last_irq, e.gap);
            end
            last_irq = cyc;
        end
    end

    // slow-clock pulse: one every 5 cycles
    initial begin
        fs_tick = 1'b0;
        forever begin
            repeat (4) step();
            fs_tick = 1'b1;
            step();
            fs_tick = 1'b0;
        end
    end

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int c;
        longint t0;
        rst = 1'b1; div_opt = 1'b0; slow_mode = 1'b0; chain_in = 1'b0;
        ctrl = 8'h00; cmp = 8'd5; ctrl_hi = 8'h40; cmp_hi = 8'd3;
        repeat (4) step();
        rst = 1'b0;
        step();
        chk("R1 count after reset", count, 0);
        chk("R1 irq after reset", irq, 0);

        // R3 / R10: chain ticks with compare 5
        restart(8'h48);
        repeat (4) ctick();
        chk("R3 count after 4 ticks", count, 4);
        chk("R3 no irq before match", irq, 0);
        ctick();
        chk("R3 irq on 5th tick", irq, 1);
        chk("R3 count cleared on match", count, 0);
        step();
        chk("R3 irq lasts one cycle", irq, 0);

        // R10: selects 5..7 give no tick
        repeat (2) ctick();
        ctrl = 8'h58;
        repeat (3) ctick();
        chk("R10 select 5 ignores chain", count, 2);
        ctrl = 8'h78;
        repeat (3) ctick();
        chk("R10 select 7 ignores chain", count, 2);

        // R2: stopped and wrong mode
        ctrl = 8'h40;
        step();
        chk("R2 stop clears count", count, 0);
        c = irq_cnt;
        repeat (6) ctick();
        step();
        chk("R2 stopped count", count, 0);
        chk("R2 stopped no irq", irq_cnt, c);
        ctrl = 8'h49;
        repeat (3) ctick();
        chk("R2 non-timer mode holds zero", count, 0);

        // R2 restart then R6 compare write on the deciding tick
        restart(8'h48);
        repeat (2) ctick();
        chk("R2 restart counts from zero", count, 2);
        cmp = 8'd3;
        ctick();
        chk("R6 new compare matches at once", irq, 1);
        chk("R6 count cleared", count, 0);

        // R5: compare below count waits for wrap
        cmp = 8'd10;
        restart(8'h48);
        repeat (6) ctick();
        cmp = 8'd4;
        c = irq_cnt;
        repeat (249) ctick();
        chk("R5 count reaches 255", count, 255);
        ctick();
        chk("R5 wrap to zero", count, 0);
        chk("R5 no irq at wrap", irq, 0);
        repeat (3) ctick();
        step();
        chk("R5 no irq through wrap", irq_cnt, c);
        ctick();
        chk("R5 match after wrap", irq, 1);

        // R4: compare 0 means 256 ticks
        cmp = 8'd0;
        restart(8'h48);
        c = irq_cnt;
        repeat (255) ctick();
        chk("R4 count 255 no match", count, 255);
        ctick();
        chk("R4 irq on 256th tick", irq, 1);
        chk("R4 count cleared", count, 0);
        step();
        chk("R4 one irq in 256 ticks", irq_cnt, c + 1);

        // R11: run cleared together with matching tick
        cmp = 8'd3;
        restart(8'h48);
        repeat (2) ctick();
        chain_in = 1'b1;
        ctrl = 8'h40;
        step();
        chain_in = 1'b0;
        chk("R11 no irq when stopped on match", irq, 0);
        chk("R11 count zero", count, 0);

        // R7: prescaled ticks
        cmp = 8'd2; restart(8'h08); expect_gap("R7 select 0 gap", 2 * 2048);
        cmp = 8'd3; restart(8'h18); expect_gap("R7 select 1 gap", 3 * 128);
        cmp = 8'd4; restart(8'h28); expect_gap("R7 select 2 gap", 4 * 32);
        cmp = 8'd5; restart(8'h38); expect_gap("R7 select 3 gap", 5 * 8);

        // R8: divider option
        div_opt = 1'b1;
        cmp = 8'd2; restart(8'h08); expect_gap("R8 select 0 slow gap", 2 * 8 * 5);
        cmp = 8'd5; restart(8'h38); expect_gap("R8 select 3 unchanged", 5 * 8);

        // R9: slow mode
        div_opt = 1'b0;
        slow_mode = 1'b1;
        cmp = 8'd3; restart(8'h08); expect_gap("R9 select 0 slow gap", 3 * 8 * 5);
        cmp = 8'd20; restart(8'h28);
        c = irq_cnt;
        repeat (300) step();
        chk("R9 select 2 stopped in slow mode", count, 0);
        chk("R9 no irq in slow mode", irq_cnt, c);
        slow_mode = 1'b0;

        // R10: chained 16-bit operation
        cmp = 8'd5; restart(8'h38);
        ctrl_hi = 8'h48;
        while (!irq_hi) step();
        t0 = $time;
        step();
        while (!irq_hi) step();
        chk("R10 chained upper interval", int'(($time - t0) / 10), 3 * 5 * 8);

        summary();
    end

endmodule